// File: doc/BRIEF.md
# Register File with Narrow-Slice Views

This block is a general-purpose register file of `NUM_REGS` 32-bit registers with one write port and two read ports. Each port gives a register index and a two-bit access-size code. The first `NUM_SPLIT` registers (indices 0 to 3 by default) can also be used through three narrower views: the lower 16 bits, the lowest byte, and the byte directly above the lowest byte. The remaining registers act as pointer and index holders and can only be accessed as whole words.

A narrow write changes only the bits of its slice, so the untouched bits of the register keep their value. A narrow read returns its slice shifted down to bit 0 of the read bus, with zeros above it. A narrow access to a register outside the first four is rejected. The write port raises its error strobe and commits nothing. A read port raises its error strobe and returns zero. When a read and a legal write address the same register in one cycle, the read returns the merged value that the write is about to store.

Top module: `subreg_regfile`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero at full size on both read ports.
- R2: Size code 0 (word) writes and reads all 32 bits of any register from index 0 to 7.
- R3: Size code 1 (half), on registers 0 to 3, reads bits 15:0 zero-extended to 32 bits. A write with this code replaces bits 15:0 from write-data bits 15:0.
- R4: Size code 2 (low byte), on registers 0 to 3, reads bits 7:0 zero-extended. A write with this code replaces bits 7:0 from write-data bits 7:0.
- R5: Size code 3 (high byte), on registers 0 to 3, reads bits 15:8 and returns them in read-bus bits 7:0 with zeros above. A write with this code puts write-data bits 7:0 into register bits 15:8.
- R6: A narrow write (codes 1 to 3) leaves every register bit outside its slice unchanged, and no write changes any other register.
- R7: A write with size code 1, 2 or 3 to a register with index 4 to 7 raises the write error strobe in the same cycle and leaves every register unchanged.
- R8: A read with size code 1, 2 or 3 of a register with index 4 to 7 raises that port's error strobe and returns zero.
- R9: When a read port and a legal write address the same register in one cycle, that cycle's read data is the slice of the value after the merge. A rejected write is not forwarded.
- R10: The two read ports decode index and size independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request this cycle |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write size code (0 word, 1 half, 2 low byte, 3 high byte) |
| wr_data | input | 32 | Write data, slice taken from its low bits |
| wr_err | output | 1 | Write index/size combination is illegal |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 32 | Read port A data, zero-extended slice |
| rd_a_err | output | 1 | Read port A combination is illegal |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B data, zero-extended slice |
| rd_b_err | output | 1 | Read port B combination is illegal |

## Verification
The read paths are combinational, so any corrupted register bit shows on the read bus in the cycle right after the faulty write. The bench sweeps every index and size on the write port. After each write it reads every slice back on both ports. A merge mask that spans too much or too little shows up as a changed neighbour byte in the next read. A wrong forwarding path or a wrong legality decision shows up at the ports in the same cycle as the write.

// File: rtl/subreg_pkg.sv
// Shared types for the slice-addressable register file.
// Assumes the size code is two bits wide and that the encoding below is fixed.
package subreg_pkg;
    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,   // whole register
        SZ_HALF = 2'd1,   // bits 15:0
        SZ_LOW  = 2'd2,   // bits 7:0
        SZ_HIGH = 2'd3    // bits 15:8
    } acc_size_e;
endpackage

// File: rtl/slice_decode.sv
// Turns a register index and a size code into an in-place bit mask and a
// right-shift amount, and decides whether the combination is legal.
// Assumes DATA_W >= 2*LANE_W and NUM_SPLIT <= NUM_REGS.
module slice_decode
    import subreg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LANE_W    = 8,
    parameter int NUM_REGS  = 8,
    parameter int NUM_SPLIT = 4,
    parameter int IDX_W     = $clog2(NUM_REGS),
    parameter int SH_W      = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        size,
    output logic              legal,
    output logic [DATA_W-1:0] mask,
    output logic [SH_W-1:0]   shift
);
    localparam int HALF_W = 2 * LANE_W;
    localparam logic [DATA_W-1:0] LANE_MASK = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [IDX_W:0]    REG_LIM   = NUM_REGS[IDX_W:0];
    localparam logic [IDX_W:0]    SPLIT_LIM = NUM_SPLIT[IDX_W:0];

    acc_size_e sz;
    logic      in_range;
    logic      splittable;

    // Select the slice mask and shift for the requested size.
    always_comb begin
        sz = acc_size_e'(size);
        unique case (sz)
            SZ_WORD: begin mask = '1;                 shift = '0; end
            SZ_HALF: begin mask = HALF_MASK;          shift = '0; end
            SZ_LOW:  begin mask = LANE_MASK;          shift = '0; end
            default: begin mask = LANE_MASK << LANE_W; shift = SH_W'(LANE_W); end
        endcase
    end

    // Narrow views exist only for the low-numbered registers.
    always_comb begin
        in_range   = ({1'b0, idx} < REG_LIM);
        splittable = ({1'b0, idx} < SPLIT_LIM);
        legal      = in_range && ((sz == SZ_WORD) || splittable);
    end
endmodule

// File: rtl/write_merge.sv
// Merges a shifted write slice into the current register value, keeping
// every bit outside the mask. Assumes the mask and shift come from slice_decode.
module write_merge #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] cur_val,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mask,
    input  logic [SH_W-1:0]   shift,
    output logic [DATA_W-1:0] new_val
);
    // Place the slice in position and keep the untouched bits.
    always_comb begin
        new_val = (cur_val & ~mask) | ((wdata << shift) & mask);
    end
endmodule

// File: rtl/read_extract.sv
// Cuts a slice out of a register value and moves it down to bit 0.
// An illegal access reads as zero. Assumes the mask and shift come from slice_decode.
module read_extract #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_val,
    input  logic              legal,
    input  logic [DATA_W-1:0] mask,
    input  logic [SH_W-1:0]   shift,
    output logic [DATA_W-1:0] rdata
);
    // Mask, align and zero-fill the slice.
    always_comb begin
        rdata = legal ? ((src_val & mask) >> shift) : '0;
    end
endmodule

// File: rtl/subreg_regfile.sv
// Register file with one write and two read ports. Each port addresses a
// register at word, half, low-byte or high-byte size. Narrow writes merge
// into the old value. A read of the register being written sees the merged value.
// Assumes a single clock and a synchronous active-low reset.
module subreg_regfile
    import subreg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LANE_W    = 8,
    parameter int NUM_REGS  = 8,
    parameter int NUM_SPLIT = 4,
    parameter int IDX_W     = $clog2(NUM_REGS),
    parameter int NUM_RD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [1:0]        rd_a_size,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_err,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [1:0]        rd_b_size,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_err
);
    localparam int SH_W   = $clog2(DATA_W);
    localparam int HALF_W = 2 * LANE_W;

    logic [DATA_W-1:0] regs [NUM_REGS];

    logic              wr_legal;
    logic [DATA_W-1:0] wr_mask;
    logic [SH_W-1:0]   wr_shift;
    logic [DATA_W-1:0] wr_merged;
    logic              wr_commit;

    logic [IDX_W-1:0]  rd_idx  [NUM_RD];
    logic [1:0]        rd_size [NUM_RD];
    logic [DATA_W-1:0] rd_data [NUM_RD];
    logic              rd_err  [NUM_RD];

    // Bring the named read ports into indexed form.
    always_comb begin
        rd_idx[0]  = rd_a_idx;
        rd_size[0] = rd_a_size;
        rd_idx[1]  = rd_b_idx;
        rd_size[1] = rd_b_size;
    end

    assign rd_a_data = rd_data[0];
    assign rd_a_err  = rd_err[0];
    assign rd_b_data = rd_data[1];
    assign rd_b_err  = rd_err[1];

    slice_decode #(
        .DATA_W(DATA_W), .LANE_W(LANE_W), .NUM_REGS(NUM_REGS),
        .NUM_SPLIT(NUM_SPLIT), .IDX_W(IDX_W), .SH_W(SH_W)
    ) i_wr_dec (
        .idx(wr_idx), .size(wr_size),
        .legal(wr_legal), .mask(wr_mask), .shift(wr_shift)
    );

    write_merge #(.DATA_W(DATA_W), .SH_W(SH_W)) i_wr_merge (
        .cur_val(regs[wr_idx]), .wdata(wr_data),
        .mask(wr_mask), .shift(wr_shift), .new_val(wr_merged)
    );

    // Flag illegal writes and qualify the commit.
    always_comb begin
        wr_err    = !wr_legal;
        wr_commit = wr_en && wr_legal;
    end

    // Register storage: clear on reset, store the merged value on a legal write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_commit) begin
            regs[wr_idx] <= wr_merged;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic              legal;
        logic [DATA_W-1:0] mask;
        logic [SH_W-1:0]   shift;
        logic [DATA_W-1:0] src;

        slice_decode #(
            .DATA_W(DATA_W), .LANE_W(LANE_W), .NUM_REGS(NUM_REGS),
            .NUM_SPLIT(NUM_SPLIT), .IDX_W(IDX_W), .SH_W(SH_W)
        ) i_rd_dec (
            .idx(rd_idx[p]), .size(rd_size[p]),
            .legal(legal), .mask(mask), .shift(shift)
        );

        // Forward the merged value when this port reads the register being written.
        always_comb begin
            src = (wr_commit && (rd_idx[p] == wr_idx)) ? wr_merged : regs[rd_idx[p]];
        end

        read_extract #(.DATA_W(DATA_W), .SH_W(SH_W)) i_rd_ext (
            .src_val(src), .legal(legal), .mask(mask), .shift(shift),
            .rdata(rd_data[p])
        );

        assign rd_err[p] = !legal;

        AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rd_err[p] |-> (rd_data[p] == '0));  // R8
        AST_RD_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_err[p] && (rd_size[p] != 2'd0)) |-> (rd_data[p][DATA_W-1:HALF_W] == '0));  // R3
        AST_RD_BYPASS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_err && (wr_size == 2'd0) && (rd_idx[p] == wr_idx)
             && (rd_size[p] == 2'd0)) |-> (rd_data[p] == wr_data));  // R9
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        AST_OTHER_REG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && !wr_err && (wr_idx == IDX_W'(r))) |=> $stable(regs[r]));  // R6
        AST_LOW_WRITE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == IDX_W'(r)) && (wr_size == 2'd2))
            |=> (regs[r][DATA_W-1:LANE_W] == $past(regs[r][DATA_W-1:LANE_W])));  // R6
        AST_ILLEGAL_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_err) |=> $stable(regs[r]));  // R7
    end
endmodule

// File: tb/test_subreg_regfile.sv
// Sweeps every index and size on the write port and reads every slice back.
module test_subreg_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_size;
    logic [31:0] wr_data;
    logic        wr_err;
    logic [2:0]  rd_a_idx, rd_b_idx;
    logic [1:0]  rd_a_size, rd_b_size;
    logic [31:0] rd_a_data, rd_b_data;
    logic        rd_a_err, rd_b_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [31:0] model [8];

    always #5 clk = ~clk;

    subreg_regfile i_subreg_regfile (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
        .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data), .rd_a_err(rd_a_err),
        .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data), .rd_b_err(rd_b_err)
    );

    function automatic bit illegal(input int idx, input int sz);
        return (sz != 0) && (idx >= 4);
    endfunction

    function automatic logic [31:0] slice_of(input logic [31:0] v, input int sz);
        case (sz)
            0: return v;
            1: return v % 32'd65536;
            2: return v % 32'd256;
            default: return (v / 32'd256) % 32'd256;
        endcase
    endfunction

    function automatic logic [31:0] merged(input logic [31:0] old, input int sz, input logic [31:0] d);
        case (sz)
            0: return d;
            1: return (old - old % 32'd65536) + d % 32'd65536;
            2: return (old - old % 32'd256) + d % 32'd256;
            default: return old - ((old / 32'd256) % 32'd256) * 32'd256 + (d % 32'd256) * 32'd256;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive both read ports and compare data and error strobes.
    task automatic read_both(input string req, input int ia, input int sa, input int ib, input int sb);
        rd_a_idx = 3'(ia); rd_a_size = 2'(sa);
        rd_b_idx = 3'(ib); rd_b_size = 2'(sb);
        #1;
        check({req, " portA data"}, rd_a_data, illegal(ia, sa) ? 32'd0 : slice_of(model[ia], sa));
        check({req, " portA err"},  {31'd0, rd_a_err}, {31'd0, illegal(ia, sa)});
        check({req, " portB data"}, rd_b_data, illegal(ib, sb) ? 32'd0 : slice_of(model[ib], sb));
        check({req, " portB err"},  {31'd0, rd_b_err}, {31'd0, illegal(ib, sb)});
    endtask

    // One write cycle: check the strobe before the edge, then update the model.
    task automatic do_write(input string req, input int idx, input int sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_size = 2'(sz); wr_data = d;
        #1;
        check({req, " wr_err"}, {31'd0, wr_err}, {31'd0, illegal(idx, sz)});
        @(posedge clk);
        if (!illegal(idx, sz)) model[idx] = merged(model[idx], sz, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = 32'd0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                done = 1'b1;
                failures++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
        rd_a_idx = '0; rd_a_size = '0; rd_b_idx = '0; rd_b_size = '0;
        rst_n = 1'b0;
        apply_reset();

        // R1: every register reads zero after reset.
        @(negedge clk);
        for (int r = 0; r < 8; r++) read_both("R1", r, 0, 7 - r, 0);

        // R2-R8, R10: sweep every index and size, then read all slices back.
        for (int r = 0; r < 8; r++) begin
            for (int s = 0; s < 4; s++) begin
                do_write("R2 background", r, 0, 32'hA5C3_0F1E ^ (32'(r) * 32'h0101_0101));
                do_write(s == 0 ? "R2" : (r >= 4 ? "R7" : (s == 1 ? "R3" : (s == 2 ? "R4" : "R5"))),
                         r, s, 32'h9E37_79B9 * 32'(r * 4 + s + 1));
                for (int q = 0; q < 4; q++)
                    read_both("R6 R8 R10", r, q, (r + q + 1) % 8, 3 - q);
            end
        end

        // R9: a legal write forwards to both ports in the same cycle.
        do_write("R9 setup", 2, 0, 32'h1122_3344);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_size = 2'd3; wr_data = 32'h0000_00BE;
        rd_a_idx = 3'd2; rd_a_size = 2'd0; rd_b_idx = 3'd2; rd_b_size = 2'd3;
        #1;
        check("R9 bypass word", rd_a_data, 32'h1122_BE44);
        check("R9 bypass high", rd_b_data, 32'h0000_00BE);
        @(posedge clk);
        model[2] = 32'h1122_BE44;
        @(negedge clk);
        wr_en = 1'b0;

        // R9/R7: a rejected write is not forwarded and changes nothing.
        do_write("R9 setup", 5, 0, 32'hCAFE_F00D);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd5; wr_size = 2'd2; wr_data = 32'h0000_0011;
        rd_a_idx = 3'd5; rd_a_size = 2'd0; rd_b_idx = 3'd5; rd_b_size = 2'd2;
        #1;
        check("R9 no forward of rejected write", rd_a_data, 32'hCAFE_F00D);
        check("R8 narrow read of reg 5", rd_b_data, 32'd0);
        check("R7 wr_err", {31'd0, wr_err}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        read_both("R7 after rejected write", 5, 0, 2, 0);

        // R1: reset again after activity.
        apply_reset();
        @(negedge clk);
        for (int r = 0; r < 8; r++) read_both("R1 second reset", r, 0, r, (r < 4) ? 1 : 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule